// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a countdown watchdog for a processor subsystem. Once enabled, it counts clock cycles against a period taken from a 3-bit select field. Software must prove it is alive by writing two fixed key bytes, 0x55 and then 0xAA, to a service register before the period runs out. Any number of unrelated bus accesses may sit between the two keys. A correct pair restarts the count from zero.

If the count reaches the end of the period, a timeout flag is set in the control register. That timeout is then pending. A select bit in the control register decides what a timeout does. It either raises an interrupt request, or it raises an internal reset request and sets a sticky status flag that records a watchdog-caused reset. While a timeout is pending, the control register can be read, and its flag bit can be cleared, but no other field can be written. A new period is therefore loaded by clearing the flag, disabling, servicing, and writing the period together with the enable.

The register interface is a plain strobe bus. Writes take effect at the clock edge, and read data is returned combinationally in the same cycle.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, the control register reads 0x00 and the status register reads 0x00. `irq_o`, `rst_req_o` and `wdr_flag_o` are low, and no timeout occurs however long the clock runs.
- R2: The control register (address 0) has these fields: bit 7 enable, bit 6 action select, bits 5:3 period select n, bits 2 and 1 plain storage bits, bit 0 timeout flag. With enable set and the count starting at zero, the flag sets exactly 2^(9+2n) cycles after enable is registered. While enable is 0 the count holds its value.
- R3: Writing 0x55 and then 0xAA to the service register (address 1) clears the count at the 0xAA write. Reads and other register writes between the two keys do not break the sequence.
- R4: A service write of any value other than the expected key returns the sequence to waiting for 0x55, and the count is not cleared.
- R5: On timeout with the action select at 0, bit 0 of the control register sets and `irq_o` goes high, while `rst_req_o` stays low.
- R6: On timeout with the action select at 1, `rst_req_o` goes high and the status flag (address 2 bit 0, also on `wdr_flag_o`) sets. The status flag stays set after the timeout is cleared, and only `rst_ni` clears it.
- R7: While the timeout flag is set, control writes leave bits 7:1 unchanged. Writing 1 to bit 0 clears the flag at any time, which drops `irq_o` and `rst_req_o`. Writing 0 to bit 0 never changes it.
- R8: Reads return the control register at address 0, zero at address 1, {7'b0, status flag} at address 2, and zero at address 3. `rdata_o` is zero whenever `rd_en_i` is low.
- R9: If the 0xAA key completes a service in the same cycle in which the count reaches the end of the period, the service wins: no timeout is raised and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low power-on reset, asynchronous |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational |
| irq_o | output | 1 | Interrupt request while a timeout is pending in interrupt mode |
| rst_req_o | output | 1 | Internal reset request while a timeout is pending in reset mode |
| wdr_flag_o | output | 1 | Sticky watchdog-reset status flag |

## Verification
Two events can land in the same cycle: the count reaching the last cycle of its period, and the 0xAA write that completes a service. The bench counts edges from the enable write and places the 0x55 key early. It then places the 0xAA key so that it is sampled on exactly the edge at which the timeout would otherwise register. The check passes only if the flag stays clear and the next timeout comes one full period after that edge. A second run moves the 0xAA key one cycle later, and there the flag must already be set, which shows that the first run really hit the boundary.

// File: rtl/svc_wdog_pkg.sv
`timescale 1ns/1ps
package svc_wdog_pkg;

    localparam int REG_CTRL   = 0;
    localparam int REG_SVC    = 1;
    localparam int REG_STATUS = 2;

    localparam int CTL_EN      = 7;
    localparam int CTL_ACT     = 6;
    localparam int CTL_PER_LSB = 3;
    localparam int CTL_FLAG    = 0;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic {
        KS_WAIT_FIRST  = 1'b0,
        KS_WAIT_SECOND = 1'b1
    } key_state_e;

    typedef struct packed {
        logic [7:0] ctrl;
        logic       wdr;
    } wd_regs_t;

endpackage

// File: rtl/wdog_key_seq.sv
`timescale 1ns/1ps
module wdog_key_seq
    import svc_wdog_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       key_wr_i,
    input  logic [7:0] key_data_i,
    output logic       service_o
);

    key_state_e state_d, state_q;

    always_comb begin
        state_d   = state_q;
        service_o = 1'b0;
        if (key_wr_i) begin
            if (state_q == KS_WAIT_FIRST && key_data_i == KEY_FIRST) begin
                state_d = KS_WAIT_SECOND;
            end else if (state_q == KS_WAIT_SECOND && key_data_i == KEY_SECOND) begin
                state_d   = KS_WAIT_FIRST;
                service_o = 1'b1;
            end else begin
                state_d = KS_WAIT_FIRST;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= KS_WAIT_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
    parameter int BASE_LOG2 = 9,
    parameter int STEP_LOG2 = 2,
    parameter int SEL_W     = 3,
    parameter int CNT_W     = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    localparam int NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] term_tbl [NSEL];
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    for (genvar g = 0; g < NSEL; g++) begin : g_term
        localparam int LG = BASE_LOG2 + STEP_LOG2 * g;
        assign term_tbl[g] = CNT_W'((64'd1 << LG) - 64'd1);
    end

    assign at_end   = (cnt_q >= term_tbl[sel_i]);
    assign expire_o = run_i && !clear_i && at_end;
    assign cnt_o    = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/svc_watchdog.sv
`timescale 1ns/1ps
module svc_watchdog
    import svc_wdog_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int BASE_LOG2 = 9,
    parameter int STEP_LOG2 = 2,
    parameter int SEL_W     = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic              wdr_flag_o
);

    localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1);

    wd_regs_t         regs_d, regs_q;
    logic             ctrl_wr, svc_wr, service, expire, pending;
    logic [CNT_W-1:0] cnt;

    assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));
    assign svc_wr  = wr_en_i && (addr_i == ADDR_W'(REG_SVC));
    assign pending = regs_q.ctrl[CTL_FLAG];

    wdog_key_seq u_keys (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .key_wr_i   (svc_wr),
        .key_data_i (wdata_i),
        .service_o  (service)
    );

    wdog_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .SEL_W     (SEL_W),
        .CNT_W     (CNT_W)
    ) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (regs_q.ctrl[CTL_EN]),
        .clear_i  (service),
        .sel_i    (regs_q.ctrl[CTL_PER_LSB +: SEL_W]),
        .cnt_o    (cnt),
        .expire_o (expire)
    );

    always_comb begin
        regs_d = regs_q;
        if (ctrl_wr) begin
            if (!pending) begin
                regs_d.ctrl[7:1] = wdata_i[7:1];
            end
            if (wdata_i[CTL_FLAG]) begin
                regs_d.ctrl[CTL_FLAG] = 1'b0;
            end
        end
        if (expire && !pending) begin
            regs_d.ctrl[CTL_FLAG] = 1'b1;
            if (regs_d.ctrl[CTL_ACT]) begin
                regs_d.wdr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        if (rd_en_i) begin
            if (addr_i == ADDR_W'(REG_CTRL)) begin
                rdata_o = regs_q.ctrl;
            end else if (addr_i == ADDR_W'(REG_STATUS)) begin
                rdata_o = {7'b0, regs_q.wdr};
            end
        end
    end

    assign irq_o      = pending && !regs_q.ctrl[CTL_ACT];
    assign rst_req_o  = pending &&  regs_q.ctrl[CTL_ACT];
    assign wdr_flag_o = regs_q.wdr;

endmodule

// File: rtl/svc_watchdog_chk.sv
`timescale 1ns/1ps
module svc_watchdog_chk #(
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 23
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [7:0]        ctrl_q,
    input logic              rst_req_o,
    input logic              wdr_flag_o,
    input logic              service,
    input logic [CNT_W-1:0]  cnt
);

    assert_service_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        service |=> (cnt == '0));

    assert_hold_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_q[7] && !service) |=> $stable(cnt));

    assert_ctrl_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == '0 && ctrl_q[0]) |=> (ctrl_q[7:1] == $past(ctrl_q[7:1])));

    assert_status_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(wdr_flag_o));

    assert_reset_sets_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> wdr_flag_o);

    assert_service_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (service && !ctrl_q[0]) |=> !ctrl_q[0]);

endmodule

bind svc_watchdog svc_watchdog_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .ctrl_q     (regs_q.ctrl),
    .rst_req_o  (rst_req_o),
    .wdr_flag_o (wdr_flag_o),
    .service    (service),
    .cnt        (cnt)
);

// File: tb/svc_watchdog_tb_top.sv
`timescale 1ns/1ps
module svc_watchdog_tb_top;

    localparam int P0 = 512;
    localparam int P1 = 2048;
    localparam int NV = 10;

    // {do_wr, waddr[1:0], wdata[7:0], raddr[1:0], expected[7:0]}
    localparam logic [20:0] VECS [NV] = '{
        {1'b1, 2'd0, 8'h7E, 2'd0, 8'h7E},
        {1'b1, 2'd0, 8'h7F, 2'd0, 8'h7E},
        {1'b1, 2'd0, 8'h06, 2'd0, 8'h06},
        {1'b1, 2'd0, 8'h40, 2'd0, 8'h40},
        {1'b0, 2'd0, 8'h00, 2'd1, 8'h00},
        {1'b0, 2'd0, 8'h00, 2'd2, 8'h00},
        {1'b1, 2'd1, 8'h55, 2'd1, 8'h00},
        {1'b1, 2'd1, 8'h12, 2'd0, 8'h40},
        {1'b1, 2'd0, 8'h00, 2'd0, 8'h00},
        {1'b0, 2'd0, 8'h00, 2'd3, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq, rst_req, wdr;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    svc_watchdog dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .wr_en_i    (wr_en),
        .rd_en_i    (rd_en),
        .rdata_o    (rdata),
        .irq_o      (irq),
        .rst_req_o  (rst_req),
        .wdr_flag_o (wdr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr  = a;
        rd_en = 1'b1;
        #0.5;
        v     = rdata;
        rd_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_flag(input string req, input logic exp);
        logic [7:0] v;
        rd(2'd0, v);
        check(req, {31'b0, v[0]}, {31'b0, exp});
    endtask

    task automatic quiesce();
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h55);
        wr(2'd1, 8'hAA);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd2, v); check("R1 status", v, 8'h00);
        check("R1 outputs", {irq, rst_req, wdr}, 3'b000);

        // R8/R7: register map vectors
        for (int i = 0; i < NV; i++) begin
            logic [20:0] vec;
            vec = VECS[i];
            if (vec[20]) wr(vec[19:18], vec[17:10]);
            rd(vec[9:8], v);
            check("R8 vector", v, vec[7:0]);
        end
        wr(2'd0, 8'h06);
        addr = 2'd0; rd_en = 1'b0; #0.5;
        check("R8 idle read", rdata, 8'h00);
        wr(2'd0, 8'h00);
        quiesce();

        // R2/R5: period n=0, interrupt mode
        wr(2'd0, 8'h80);
        step(P0 - 1);
        check_flag("R2 n0 before end", 1'b0);
        check("R5 irq before", irq, 1'b0);
        step(1);
        rd(2'd0, v); check("R2 n0 flag set", v, 8'h81);
        check("R5 irq/rst_req", {irq, rst_req}, 2'b10);
        // R7: lock while pending
        wr(2'd0, 8'h38);
        rd(2'd0, v); check("R7 locked write", v, 8'h81);
        check("R7 irq held", irq, 1'b1);
        wr(2'd0, 8'h01);
        rd(2'd0, v); check("R7 clear flag", v, 8'h80);
        check("R7 irq dropped", irq, 1'b0);
        quiesce();

        // R2: count holds while disabled
        wr(2'd0, 8'h80);
        step(100);
        wr(2'd0, 8'h00);
        step(1000);
        check_flag("R2 disabled no timeout", 1'b0);
        wr(2'd0, 8'h80);
        step(P0 - 101 - 1);
        check_flag("R2 resumed before end", 1'b0);
        step(1);
        check_flag("R2 resumed end", 1'b1);
        quiesce();

        // R2: period n=1
        wr(2'd0, 8'h88);
        step(P1 - 1);
        check_flag("R2 n1 before end", 1'b0);
        step(1);
        rd(2'd0, v); check("R2 n1 flag set", v, 8'h89);
        quiesce();

        // R3: keys with accesses in between
        wr(2'd0, 8'h80);
        wr(2'd1, 8'h55);
        rd(2'd0, v); check("R3 interleaved read", v, 8'h80);
        wr(2'd0, 8'h80);
        wr(2'd1, 8'hAA);
        step(P0 - 1);
        check_flag("R3 serviced no timeout", 1'b0);
        step(1);
        check_flag("R3 period after service", 1'b1);
        quiesce();

        // R4: wrong key aborts the sequence
        wr(2'd0, 8'h80);
        wr(2'd1, 8'h55);
        wr(2'd1, 8'h12);
        wr(2'd1, 8'hAA);
        step(P0 - 4);
        check_flag("R4 before end", 1'b0);
        step(1);
        check_flag("R4 not serviced", 1'b1);
        quiesce();

        // R9: service lands on the terminal cycle
        wr(2'd0, 8'h80);
        wr(2'd1, 8'h55);
        step(P0 - 2);
        wr(2'd1, 8'hAA);
        check_flag("R9 service wins", 1'b0);
        check("R9 no irq", irq, 1'b0);
        step(P0 - 1);
        check_flag("R9 next period early", 1'b0);
        step(1);
        check_flag("R9 next period end", 1'b1);
        quiesce();

        // R9: one cycle late, timeout already taken
        wr(2'd0, 8'h80);
        wr(2'd1, 8'h55);
        step(P0 - 1);
        wr(2'd1, 8'hAA);
        check_flag("R9 late service", 1'b1);
        check("R9 late irq", irq, 1'b1);
        quiesce();

        // R6: reset mode
        wr(2'd0, 8'hC0);
        step(P0 - 1);
        check("R6 before end", {rst_req, wdr}, 2'b00);
        step(1);
        check("R6 rst_req/irq/flag", {rst_req, irq, wdr}, 3'b101);
        rd(2'd2, v); check("R6 status read", v, 8'h01);
        rd(2'd0, v); check("R6 ctrl", v, 8'hC1);
        wr(2'd0, 8'h01);
        check("R6 after clear", {rst_req, wdr}, 2'b01);
        rd(2'd2, v); check("R6 status sticky", v, 8'h01);
        rd(2'd0, v); check("R7 only flag cleared", v, 8'hC0);

        // R1: power-on reset clears everything
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, v); check("R1 ctrl after reset", v, 8'h00);
        rd(2'd2, v); check("R1 status after reset", v, 8'h00);
        check("R1 flag pin", wdr, 1'b0);
        step(P0 + 10);
        check("R1 stays idle", {irq, rst_req}, 2'b00);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule